// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block drives an array of four 16-bit flash devices that share a 64-bit big-endian data bus and one address bus, split into two 32-bit halves that each have their own write strobe and output enable. A host hands it one request at a time: program one 64-bit word, erase the whole array, erase one sector, or return the devices to read mode. The block then issues the unlock bus writes the devices expect, with chip enable framing every write-enable pulse, and only on the halves the request selects.

After the command writes of a program or erase request, the block reads the target address repeatedly and watches the completion bit (lane bit 7) of every selected device. While a device is programming, that bit reads as the complement of the bit being written. While it is erasing, the bit reads 0. When every selected device reports completion, the block performs one further read so that the remaining data bits can settle, and returns that word. If too many polls pass without completion, it writes the read-mode command to abandon the operation and reports an error.

The internal data vector is little-endian: `fl_wdata[0]` and `fl_rdata[0]` are big-endian D63, and `fl_addr[0]` is the least significant address line. Half 0 is bits 31:0 (D32-D63) and half 1 is bits 63:32 (D0-D31). Device lane k occupies bits 16k+15:16k.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `req_ready`=1, `op_done`=0, `op_error`=0, `result_data`=0, `fl_ce_n`=1, `fl_we_n`=2'b11 and `fl_oe_n`=2'b11.
- R2: A program request (`req_op`=2'b00) issues exactly four writes in this order: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0, then `req_addr`/`req_data`. Each command address is zero-extended into `fl_addr`, and each command byte b appears as {8'h00,b} in every 16-bit lane of `fl_wdata`.
- R3: An erase request issues six writes: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, then 0x5555/0x10 for a whole-array erase (`req_op`=2'b01) or `req_addr`/0x30 for a sector erase (`req_op`=2'b10). Byte placement is as in R2.
- R4: A read-mode request (`req_op`=2'b11) issues a single write of 0xF0 at address 0, performs no reads, and completes with `op_error`=0.
- R5: Every write asserts `fl_we_n[h]` only for the halves set in `req_half` (bit 0 for half 0, bit 1 for half 1). Chip enable goes low at least one cycle before the write strobe falls and is still low when the strobe rises. Address and data stay stable while the strobe is low.
- R6: A write strobe and an output enable are never low together. Polling reads lower `fl_oe_n[h]` only for the selected halves.
- R7: A program operation is complete when bit 16k+7 of the read data equals bit 16k+7 of `req_data` for every device k in a selected half.
- R8: An erase operation is complete when bit 16k+7 of the read data is 1 for every device k in a selected half.
- R9: Once completion is seen, exactly one further read is made. `op_done` then pulses for one cycle with `op_error`=0, and `result_data` holds that read with unselected halves forced to zero.
- R10: Let L be `req_poll_limit`, with 0 treated as 1. When L polling reads have all shown an incomplete result, the block writes 0xF0 at address 0 and pulses `op_done` with `op_error`=1, having made exactly L reads.
- R11: While `req_ready` is low, `req_valid` is ignored. `req_ready` returns high in the cycle after `op_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_op | input | 2 | 00 program, 01 whole-array erase, 10 sector erase, 11 read mode |
| req_addr | input | ADDR_W | Target word or sector address |
| req_data | input | 64 | Word to program |
| req_half | input | 2 | Selected 32-bit halves |
| req_poll_limit | input | LIM_W | Maximum polling reads (0 acts as 1) |
| op_done | output | 1 | One-cycle completion pulse |
| op_error | output | 1 | Last operation timed out; valid with `op_done` |
| result_data | output | 64 | Final confirmation read, unselected halves zero |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_wdata | output | 64 | Flash write data |
| fl_drive | output | 1 | Write data should be driven onto the bus |
| fl_rdata | input | 64 | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 2 | Write strobe per half, active low |
| fl_oe_n | output | 2 | Output enable per half, active low |

## Verification
The assertions assume that a request always selects at least one half. They also assume that the flash side returns a stable word on `fl_rdata` for the whole length of each read window, with each new read starting when an output enable falls. The stimulus keeps `req_half` nonzero and uses a bench flash model that changes its answer only on an output-enable falling edge: it stays busy for a chosen number of reads, toggles bit 6, and shows either complemented data or zero in bit 7. Busy counts are placed below, at and above the poll limit, a zero limit is included, and a stray request is pulsed during operations.

// File: rtl/flseq_pkg.sv
// Shared constants and types for the flash program/erase sequencer.
// Assumes a 64-bit bus made of four 16-bit device lanes, two lanes per half.
package flseq_pkg;

    localparam int LANE_W         = 16;
    localparam int DATA_W         = 64;
    localparam int NUM_LANES      = DATA_W / LANE_W;
    localparam int HALF_W         = DATA_W / 2;
    localparam int LANES_PER_HALF = NUM_LANES / 2;
    localparam int CMD_ADDR_W     = 16;
    localparam int DONE_BIT       = 7;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_CHIP = 2'd1,
        OP_SECT = 2'd2,
        OP_RST  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD,
        PH_READ,
        PH_GAP
    } phase_e;

    // Place a command byte in the low byte of every device lane.
    function automatic logic [DATA_W-1:0] fill_lanes(input logic [7:0] cmd);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int k = 0; k < NUM_LANES; k++) begin
            r[k*LANE_W +: LANE_W] = {{(LANE_W-8){1'b0}}, cmd};
        end
        return r;
    endfunction

endpackage

// File: rtl/flseq_cmd_table.sv
// Command step table: gives the address and data of write number `step`
// of the sequence for `op`, and flags the last write of that sequence.
// Purely combinational; assumes ADDR_W >= 16 and step within range.
module flseq_cmd_table
    import flseq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  op_e               op,
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DATA_W-1:0] tgt_data,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              last
);

    localparam logic [CMD_ADDR_W-1:0] UNLOCK_HI = 16'h5555;
    localparam logic [CMD_ADDR_W-1:0] UNLOCK_LO = 16'h2AAA;

    logic [CMD_ADDR_W-1:0] cmd_addr;
    logic [7:0]            cmd_byte;
    logic                  use_tgt_addr;
    logic                  use_tgt_data;

    // Select the command address, byte and last-step flag for this step.
    always_comb begin
        cmd_addr     = UNLOCK_HI;
        cmd_byte     = 8'hAA;
        use_tgt_addr = 1'b0;
        use_tgt_data = 1'b0;
        last         = 1'b0;
        unique case (op)
            OP_PROG: begin
                unique case (step)
                    3'd0: begin cmd_addr = UNLOCK_HI; cmd_byte = 8'hAA; end
                    3'd1: begin cmd_addr = UNLOCK_LO; cmd_byte = 8'h55; end
                    3'd2: begin cmd_addr = UNLOCK_HI; cmd_byte = 8'hA0; end
                    default: begin
                        use_tgt_addr = 1'b1;
                        use_tgt_data = 1'b1;
                        last         = 1'b1;
                    end
                endcase
            end
            OP_CHIP, OP_SECT: begin
                unique case (step)
                    3'd0: begin cmd_addr = UNLOCK_HI; cmd_byte = 8'hAA; end
                    3'd1: begin cmd_addr = UNLOCK_LO; cmd_byte = 8'h55; end
                    3'd2: begin cmd_addr = UNLOCK_HI; cmd_byte = 8'h80; end
                    3'd3: begin cmd_addr = UNLOCK_HI; cmd_byte = 8'hAA; end
                    3'd4: begin cmd_addr = UNLOCK_LO; cmd_byte = 8'h55; end
                    default: begin
                        last = 1'b1;
                        if (op == OP_SECT) begin
                            use_tgt_addr = 1'b1;
                            cmd_byte     = 8'h30;
                        end else begin
                            cmd_addr = UNLOCK_HI;
                            cmd_byte = 8'h10;
                        end
                    end
                endcase
            end
            default: begin
                cmd_addr = '0;
                cmd_byte = 8'hF0;
                last     = 1'b1;
            end
        endcase
    end

    // Drive the bus values from either the target or the command constant.
    always_comb begin
        wr_addr = use_tgt_addr ? tgt_addr : ADDR_W'(cmd_addr);
        wr_data = use_tgt_data ? tgt_data : fill_lanes(cmd_byte);
    end

endmodule

// File: rtl/flseq_bus_timer.sv
// Bus cycle timer: runs one flash write (setup, strobe, hold, gap) or one
// read (output-enable window, gap) per start pulse and decodes the
// strobes from its phase. Assumes start is only raised while idle and
// that read data is stable by the last cycle of the read window.
module flseq_bus_timer
    import flseq_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 2,
    parameter int HOLD_CYC  = 1,
    parameter int READ_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_read,
    input  logic [1:0]        half_sel,
    input  logic [DATA_W-1:0] rd_bus,
    output logic              ce_n,
    output logic [1:0]        we_n,
    output logic [1:0]        oe_n,
    output logic              drive,
    output logic              done,
    output logic [DATA_W-1:0] rd_cap
);

    localparam int MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_B = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_C + 1);

    phase_e           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       sel_q;

    // Advance through the phases of one bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            sel_q  <= '0;
            rd_cap <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        sel_q <= half_sel;
                        if (is_read) begin
                            ph_q  <= PH_READ;
                            cnt_q <= CNT_W'(READ_CYC - 1);
                        end else begin
                            ph_q  <= PH_SETUP;
                            cnt_q <= CNT_W'(SETUP_CYC - 1);
                        end
                    end
                end
                PH_SETUP: begin
                    if (cnt_q == '0) begin
                        ph_q  <= PH_PULSE;
                        cnt_q <= CNT_W'(PULSE_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_PULSE: begin
                    if (cnt_q == '0) begin
                        ph_q  <= PH_HOLD;
                        cnt_q <= CNT_W'(HOLD_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt_q == '0) ph_q <= PH_GAP;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                PH_READ: begin
                    if (cnt_q == '0) begin
                        rd_cap <= rd_bus;
                        ph_q   <= PH_GAP;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Decode the bus strobes from the current phase.
    always_comb begin
        ce_n  = !(ph_q == PH_SETUP || ph_q == PH_PULSE ||
                  ph_q == PH_HOLD  || ph_q == PH_READ);
        we_n  = (ph_q == PH_PULSE) ? ~sel_q : 2'b11;
        oe_n  = (ph_q == PH_READ)  ? ~sel_q : 2'b11;
        drive = (ph_q == PH_SETUP || ph_q == PH_PULSE || ph_q == PH_HOLD);
        done  = (ph_q == PH_GAP);
    end

    AST_CE_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(we_n[0]) || $fell(we_n[1])) |-> $past(!ce_n)); // R5
    AST_CE_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(we_n[0]) || $rose(we_n[1])) |-> !ce_n); // R5
    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !((we_n != 2'b11) && (oe_n != 2'b11))); // R6
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (ph_q == PH_IDLE)); // R11

endmodule

// File: rtl/flseq_poll_check.sv
// Completion evaluator: inspects the completion bit of every device lane
// in the selected halves and reports whether all of them show completion.
// Program compares against the target data bit; erase expects a 1.
module flseq_poll_check
    import flseq_pkg::*;
(
    input  logic              is_erase,
    input  logic [1:0]        half_sel,
    input  logic [DATA_W-1:0] tgt_data,
    input  logic [DATA_W-1:0] rd_data,
    output logic              complete
);

    logic [NUM_LANES-1:0] lane_ok;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        localparam int BIT  = k*LANE_W + DONE_BIT;
        localparam int HALF = k / LANES_PER_HALF;
        // Judge one device lane; unselected lanes always pass.
        always_comb begin
            if (!half_sel[HALF])  lane_ok[k] = 1'b1;
            else if (is_erase)    lane_ok[k] = rd_data[BIT];
            else                  lane_ok[k] = (rd_data[BIT] == tgt_data[BIT]);
        end
    end

    assign complete = &lane_ok;

endmodule

// File: rtl/flash_cmd_seq.sv
// Flash program/erase sequencer top: accepts one request, walks the command
// table through the bus timer, polls until completion or the poll limit,
// issues an abort write on timeout, and pulses op_done.
// Assumes req_half is nonzero and the poll limit fits in LIM_W bits.
module flash_cmd_seq
    import flseq_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int LIM_W     = 16,
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 2,
    parameter int HOLD_CYC  = 1,
    parameter int READ_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_data,
    input  logic [1:0]        req_half,
    input  logic [LIM_W-1:0]  req_poll_limit,
    output logic              op_done,
    output logic              op_error,
    output logic [63:0]       result_data,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [63:0]       fl_wdata,
    output logic              fl_drive,
    input  logic [63:0]       fl_rdata,
    output logic              fl_ce_n,
    output logic [1:0]        fl_we_n,
    output logic [1:0]        fl_oe_n
);

    typedef enum logic [2:0] {
        S_IDLE, S_WRITE, S_POLL, S_SETTLE, S_ABORT, S_FIN
    } st_e;

    st_e               st_q;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [1:0]        half_q;
    logic [LIM_W-1:0]  lim_q;
    logic [LIM_W-1:0]  poll_cnt_q;
    logic [2:0]        step_q;
    logic              pend_q;
    logic              err_q;
    logic [DATA_W-1:0] result_q;

    logic              cyc_start;
    logic              cyc_read;
    logic              cyc_done;
    logic [DATA_W-1:0] rd_cap;
    op_e               tbl_op;
    logic [2:0]        tbl_step;
    logic [ADDR_W-1:0] tbl_addr;
    logic [DATA_W-1:0] tbl_data;
    logic              tbl_last;
    logic              poll_ok;
    logic [LIM_W:0]    poll_next;
    logic [DATA_W-1:0] half_mask;

    // Decide when to launch a bus cycle and what the table should produce.
    always_comb begin
        cyc_start = (st_q == S_WRITE || st_q == S_POLL ||
                     st_q == S_SETTLE || st_q == S_ABORT) && !pend_q;
        cyc_read  = (st_q == S_POLL || st_q == S_SETTLE);
        tbl_op    = (st_q == S_ABORT) ? OP_RST : op_q;
        tbl_step  = (st_q == S_ABORT) ? 3'd0 : step_q;
        poll_next = {1'b0, poll_cnt_q} + 1'b1;
        half_mask = {{HALF_W{half_q[1]}}, {HALF_W{half_q[0]}}};
    end

    flseq_cmd_table #(.ADDR_W(ADDR_W)) u_table (
        .op       (tbl_op),
        .step     (tbl_step),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .wr_addr  (tbl_addr),
        .wr_data  (tbl_data),
        .last     (tbl_last)
    );

    flseq_bus_timer #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .READ_CYC  (READ_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cyc_start),
        .is_read  (cyc_read),
        .half_sel (half_q),
        .rd_bus   (fl_rdata),
        .ce_n     (fl_ce_n),
        .we_n     (fl_we_n),
        .oe_n     (fl_oe_n),
        .drive    (fl_drive),
        .done     (cyc_done),
        .rd_cap   (rd_cap)
    );

    flseq_poll_check u_poll (
        .is_erase (op_q != OP_PROG),
        .half_sel (half_q),
        .tgt_data (data_q),
        .rd_data  (rd_cap),
        .complete (poll_ok)
    );

    // Main sequencing: accept, write steps, poll, settle, abort, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= S_IDLE;
            op_q       <= OP_RST;
            addr_q     <= '0;
            data_q     <= '0;
            half_q     <= '0;
            lim_q      <= '0;
            poll_cnt_q <= '0;
            step_q     <= '0;
            pend_q     <= 1'b0;
            err_q      <= 1'b0;
            result_q   <= '0;
        end else begin
            if (cyc_start) pend_q <= 1'b1;
            if (cyc_done)  pend_q <= 1'b0;
            unique case (st_q)
                S_IDLE: begin
                    if (req_valid) begin
                        op_q       <= op_e'(req_op);
                        addr_q     <= req_addr;
                        data_q     <= req_data;
                        half_q     <= req_half;
                        lim_q      <= (req_poll_limit == '0) ? LIM_W'(1) : req_poll_limit;
                        poll_cnt_q <= '0;
                        step_q     <= '0;
                        err_q      <= 1'b0;
                        st_q       <= S_WRITE;
                    end
                end
                S_WRITE: begin
                    if (cyc_done) begin
                        if (tbl_last) begin
                            step_q <= '0;
                            st_q   <= (op_q == OP_RST) ? S_FIN : S_POLL;
                        end else begin
                            step_q <= step_q + 1'b1;
                        end
                    end
                end
                S_POLL: begin
                    if (cyc_done) begin
                        if (poll_ok) begin
                            st_q <= S_SETTLE;
                        end else begin
                            poll_cnt_q <= poll_next[LIM_W-1:0];
                            if (poll_next >= {1'b0, lim_q}) begin
                                err_q <= 1'b1;
                                st_q  <= S_ABORT;
                            end
                        end
                    end
                end
                S_SETTLE: begin
                    if (cyc_done) begin
                        result_q <= rd_cap & half_mask;
                        st_q     <= S_FIN;
                    end
                end
                S_ABORT: begin
                    if (cyc_done) st_q <= S_FIN;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // Bus and status outputs.
    always_comb begin
        fl_addr     = cyc_read ? addr_q : tbl_addr;
        fl_wdata    = tbl_data;
        req_ready   = (st_q == S_IDLE);
        op_done     = (st_q == S_FIN);
        op_error    = err_q;
        result_data = result_q;
    end

    AST_ADDR_STABLE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        ((fl_we_n != 2'b11) && ($past(fl_we_n) != 2'b11)) |->
        ($stable(fl_addr) && $stable(fl_wdata))); // R5
    AST_OE_SEL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        ((~fl_oe_n & ~half_q) == 2'b00)); // R6
    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_IDLE) |-> (poll_cnt_q <= lim_q)); // R10
    AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> req_ready); // R11
    AST_BUSY_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && req_valid) |=> ($stable(addr_q) && $stable(half_q))); // R11

endmodule

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;

    localparam int ADDR_W = 19;
    localparam int LIM_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [63:0]       req_data = '0;
    logic [1:0]        req_half = 2'b11;
    logic [LIM_W-1:0]  req_poll_limit = '0;
    logic              op_done;
    logic              op_error;
    logic [63:0]       result_data;
    logic [ADDR_W-1:0] fl_addr;
    logic [63:0]       fl_wdata;
    logic              fl_drive;
    logic [63:0]       fl_rdata;
    logic              fl_ce_n;
    logic [1:0]        fl_we_n;
    logic [1:0]        fl_oe_n;

    flash_cmd_seq #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) i_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .req_half(req_half), .req_poll_limit(req_poll_limit),
        .op_done(op_done), .op_error(op_error), .result_data(result_data),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_drive(fl_drive),
        .fl_rdata(fl_rdata), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
        .fl_oe_n(fl_oe_n)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Flash model state and bus log
    logic [1:0]        m_op = 2'd0;
    logic [63:0]       m_data = '0;
    logic [1:0]        m_half = 2'b11;
    int                m_nbusy = 0;
    int                m_rdidx = 0;
    logic              m_tog = 1'b0;
    logic [63:0]       mdata = '0;
    logic [ADDR_W-1:0] w_addr [0:15];
    logic [63:0]       w_data [0:15];
    logic [1:0]        w_half [0:15];
    int                w_cnt = 0;
    int                rd_cnt = 0;
    int                viol = 0;
    logic [1:0]        we_prev = 2'b11;
    logic [1:0]        oe_prev = 2'b11;

    assign fl_rdata = {fl_oe_n[1] ? 32'hA5A5A5A5 : mdata[63:32],
                       fl_oe_n[0] ? 32'h5A5A5A5A : mdata[31:0]};

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rep(input logic [7:0] b);
        return {8'h00, b, 8'h00, b, 8'h00, b, 8'h00, b};
    endfunction

    function automatic logic [63:0] half_mask(input logic [1:0] h);
        return {{32{h[1]}}, {32{h[0]}}};
    endfunction

    // Model answer for a read while busy or finished
    function automatic logic [63:0] model_word(input bit busy, input logic tog);
        logic [63:0] r;
        for (int k = 0; k < 4; k++) begin
            logic [15:0] lane;
            if (m_op == 2'd0) begin
                lane = m_data[k*16 +: 16];
                if (busy) begin
                    lane[7] = ~lane[7];
                    lane[6] = tog;
                end
            end else begin
                lane = busy ? {9'd0, tog, 6'd0} : 16'hFFFF;
            end
            r[k*16 +: 16] = lane;
        end
        return r;
    endfunction

    // Bus monitor and flash model, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [1:0] rose;
            logic [1:0] fell;
            rose = ~we_prev & fl_we_n;
            fell = oe_prev & ~fl_oe_n;
            if (rose != 2'b00 && w_cnt < 16) begin
                w_addr[w_cnt] = fl_addr;
                w_data[w_cnt] = fl_wdata;
                w_half[w_cnt] = rose;
                w_cnt++;
            end
            if (fl_we_n != 2'b11 && fl_ce_n) viol++;
            if (fl_we_n != 2'b11 && fl_oe_n != 2'b11) viol++;
            if ((~fl_oe_n & ~m_half) != 2'b00) viol++;
            if (fell != 2'b00) begin
                rd_cnt++;
                m_rdidx++;
                m_tog = ~m_tog;
                mdata = model_word(m_rdidx <= m_nbusy, m_tog);
            end
        end
        we_prev = fl_we_n;
        oe_prev = fl_oe_n;
    end

    function automatic logic [ADDR_W-1:0] exp_addr(input logic [1:0] op, input int idx,
                                                  input logic [ADDR_W-1:0] ta);
        logic [15:0] a;
        case (idx)
            0, 2, 3: a = 16'h5555;
            1, 4:    a = 16'h2AAA;
            default: a = 16'h5555;
        endcase
        if (op == 2'd3) return '0;
        if (op == 2'd0 && idx == 3) return ta;
        if (op == 2'd2 && idx == 5) return ta;
        return ADDR_W'(a);
    endfunction

    function automatic logic [63:0] exp_data(input logic [1:0] op, input int idx,
                                            input logic [63:0] td);
        if (op == 2'd3) return rep(8'hF0);
        if (op == 2'd0) begin
            case (idx)
                0: return rep(8'hAA);
                1: return rep(8'h55);
                2: return rep(8'hA0);
                default: return td;
            endcase
        end
        case (idx)
            0, 3: return rep(8'hAA);
            1, 4: return rep(8'h55);
            2:    return rep(8'h80);
            default: return (op == 2'd1) ? rep(8'h10) : rep(8'h30);
        endcase
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [ADDR_W-1:0] ad,
                          input logic [63:0] dt, input logic [1:0] hf,
                          input int lim, input int nbusy, input bit poke);
        int  cyc;
        int  leff;
        bit  exp_err;
        int  nwr;
        int  nrd;
        string tag;
        while (!req_ready) @(negedge clk);
        m_op = op; m_data = dt; m_half = hf; m_nbusy = nbusy; m_rdidx = 0;
        w_cnt = 0; rd_cnt = 0; viol = 0;
        req_op = op; req_addr = ad; req_data = dt; req_half = hf;
        req_poll_limit = LIM_W'(lim);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!op_done && cyc < 5000) begin
            if (poke && cyc == 3) begin
                req_valid = 1'b1; req_op = 2'd3;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        chk(cyc < 5000, "R9", "operation timed out", 64'(cyc), 64'd5000);

        leff    = (lim == 0) ? 1 : lim;
        exp_err = (op != 2'd3) && (nbusy >= leff);
        nwr     = (op == 2'd0) ? 4 : (op == 2'd3) ? 1 : 6;
        tag     = (op == 2'd0) ? "R2" : (op == 2'd3) ? "R4" : "R3";
        chk(op_error == exp_err, "R10", "error flag", 64'(op_error), 64'(exp_err));
        if (exp_err) nwr = nwr + 1;
        chk(w_cnt == nwr, tag, "write count", 64'(w_cnt), 64'(nwr));
        for (int i = 0; i < nwr && i < w_cnt; i++) begin
            bit is_abort;
            logic [ADDR_W-1:0] ea;
            logic [63:0] ed;
            is_abort = exp_err && (i == nwr - 1);
            ea = is_abort ? '0 : exp_addr(op, i, ad);
            ed = is_abort ? rep(8'hF0) : exp_data(op, i, dt);
            chk(w_addr[i] == ea, is_abort ? "R10" : tag, "write address",
                64'(w_addr[i]), 64'(ea));
            chk((w_data[i] & half_mask(hf)) == (ed & half_mask(hf)),
                is_abort ? "R10" : tag, "write data",
                w_data[i] & half_mask(hf), ed & half_mask(hf));
            chk(w_half[i] == hf, "R5", "strobed halves", 64'(w_half[i]), 64'(hf));
        end
        nrd = (op == 2'd3) ? 0 : exp_err ? leff : nbusy + 2;
        chk(rd_cnt == nrd, (op == 2'd0) ? "R7" : (op == 2'd3) ? "R4" : "R8",
            "read count", 64'(rd_cnt), 64'(nrd));
        chk(viol == 0, "R6", "strobe overlap or unselected strobe", 64'(viol), 64'd0);
        if (!exp_err && op != 2'd3) begin
            logic [63:0] er;
            er = model_word(1'b0, 1'b0) & half_mask(hf);
            chk(result_data == er, "R9", "result word", result_data, er);
        end
        if (poke) chk(w_cnt == nwr, "R11", "request while busy ignored",
                      64'(w_cnt), 64'(nwr));
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready after done", 64'(req_ready), 64'd1);
    endtask

    // Watchdog
    initial begin
        #(5ns * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && op_done == 1'b0 && op_error == 1'b0, "R1",
            "status after reset", {61'd0, req_ready, op_done, op_error}, 64'h4);
        chk(fl_ce_n == 1'b1 && fl_we_n == 2'b11 && fl_oe_n == 2'b11, "R1",
            "strobes after reset", {59'd0, fl_ce_n, fl_we_n, fl_oe_n}, 64'h1F);
        chk(result_data == 64'd0, "R1", "result after reset", result_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner cases
        run_op(2'd0, 19'h12345, 64'h0123_4567_89AB_CDEF, 2'b11, 3, 0, 1'b0); // R2 R7 immediate
        run_op(2'd0, 19'h00F00, 64'hFF80_0000_7F7F_0080, 2'b01, 4, 3, 1'b1); // R7 limit-1
        run_op(2'd0, 19'h00F00, 64'hFF80_0000_7F7F_0080, 2'b10, 4, 4, 1'b0); // R10 at limit
        run_op(2'd1, 19'h00000, 64'h0, 2'b11, 0, 1, 1'b0);                  // R10 zero limit
        run_op(2'd1, 19'h00000, 64'h0, 2'b11, 5, 2, 1'b0);                  // R3 R8
        run_op(2'd2, 19'h7C000, 64'h0, 2'b01, 6, 1, 1'b1);                  // R3 sector
        run_op(2'd3, 19'h1ABCD, 64'h0, 2'b11, 2, 5, 1'b1);                  // R4 R11

        // Constrained random operations
        for (int n = 0; n < 40; n++) begin
            logic [1:0] op;
            logic [1:0] hf;
            op = 2'($urandom_range(0, 3));
            hf = 2'($urandom_range(1, 3));
            run_op(op, ADDR_W'($urandom), {$urandom, $urandom}, hf,
                   int'($urandom_range(0, 6)), int'($urandom_range(0, 7)),
                   bit'($urandom_range(0, 1)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule